// File: doc/BRIEF.md
# Sample Saturation Clamp with Status

This block sits on the sample data path of a multi-channel acquisition front end. Each incoming sample carries a channel index. The block compares the sample, as a signed 24-bit two's-complement value, with that channel's programmable low and high saturation values. Each channel has two clamps, low and high, and each is enabled separately by its own bit of an enable word. When an enabled clamp's limit is exceeded, the reported reading is replaced by the limit and a saturation status bit for that channel and side is raised.

The clamped sample appears one clock after the input strobe, with its own valid strobe. A status vector holds two bits per channel and gives the dynamic saturation state of the most recent sample seen on each channel. Register decoding and number formats other than signed integers are left to the surrounding logic. The limits and the enable word arrive as plain input vectors.

Top module: `sat_clamp`

## Requirements
- R1: After reset, out_valid is 0, out_sample is 0 and every bit of sat_stat is 0.
- R2: out_valid is 1 in exactly the cycle after a cycle with in_valid at 1, and 0 after a cycle with in_valid at 0.
- R3: When the low clamp of the sample's channel is enabled and the sample is below that channel's low value, out_sample equals the low value and status bit 2c is set (c is the zero-based channel index).
- R4: When the high clamp of the sample's channel is enabled and the sample is above that channel's high value (and R3 does not apply), out_sample equals the high value and status bit 2c+1 is set.
- R5: A sample exactly equal to a limit is not clamped: it passes unchanged and its status bit for that side is 0.
- R6: Enable word bit 2c enables the low clamp of channel c and bit 2c+1 its high clamp; 1 enables, 0 disables. A disabled clamp lets the sample pass unchanged and keeps its status bit at 0.
- R7: Comparisons are signed two's-complement on 24 bits: 0x800000 is the most negative and 0x7FFFFF the most positive sample.
- R8: Status bits of channel c change only on the clock edge that takes a valid sample of channel c; they hold otherwise, as do the bits of all other channels and out_sample.
- R9: When a sample is both below an enabled low value and above an enabled high value (low value greater than high value), out_sample equals the low value and both status bits of the channel are set.
- R10: Each channel uses only its own limits: lo_lim and hi_lim hold channel c in bits [24c+23:24c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 4 | Zero-based channel index of the sample |
| in_sample | input | 24 | Signed input sample |
| lo_lim | input | 384 | Low saturation values, 24 bits per channel |
| hi_lim | input | 384 | High saturation values, 24 bits per channel |
| clamp_en | input | 32 | Clamp enables, even bit low, odd bit high |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Clamped sample |
| sat_stat | output | 32 | Dynamic status, bit 2c low, bit 2c+1 high |

## Verification
The bench first drives samples far outside the limits with every clamp off, which tells pass-through apart from clamping. Then, with clamps on, it drives samples below, above, inside and exactly on the limits, which separates strict from inclusive compares. Extreme negative and positive codes on channels with only one side enabled expose unsigned comparison and swapped even/odd enable bits. The same sample is sent to channels with different limits, and a crossed low-above-high pair is also used, to check channel selection and the low-first priority. Idle gaps and interleaved channels show whether status bits of one channel leak into, or are cleared by, traffic on another.

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int NCH = 16,
  parameter int DW  = 24,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CW-1:0]     in_chan,
  input  logic [DW-1:0]     in_sample,
  input  logic [NCH*DW-1:0] lo_lim,
  input  logic [NCH*DW-1:0] hi_lim,
  input  logic [2*NCH-1:0]  clamp_en,
  output logic              out_valid,
  output logic [DW-1:0]     out_sample,
  output logic [2*NCH-1:0]  sat_stat
);

  logic [DW-1:0] lo_a [NCH];
  logic [DW-1:0] hi_a [NCH];
  logic [NCH-1:0] lo_en_a, hi_en_a;

  for (genvar c = 0; c < NCH; c++) begin : g_split
    assign lo_a[c]    = lo_lim[c*DW +: DW];
    assign hi_a[c]    = hi_lim[c*DW +: DW];
    assign lo_en_a[c] = clamp_en[2*c];
    assign hi_en_a[c] = clamp_en[2*c+1];
  end

  wire [DW-1:0] lo_v = lo_a[in_chan];
  wire [DW-1:0] hi_v = hi_a[in_chan];

  wire below  = $signed(in_sample) < $signed(lo_v);
  wire above  = $signed(in_sample) > $signed(hi_v);
  wire hit_lo = lo_en_a[in_chan] & below;
  wire hit_hi = hi_en_a[in_chan] & above;

  wire [DW-1:0] res = hit_lo ? lo_v : (hit_hi ? hi_v : in_sample);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= res;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sat_stat[2*c+1:2*c] <= 2'b00;
      else if (in_valid && in_chan == CW'(c))
        sat_stat[2*c+1:2*c] <= {hit_hi, hit_lo};
    end
  end

endmodule

// File: rtl/sat_clamp_chk.sv
module sat_clamp_chk #(
  parameter int NCH = 16,
  parameter int DW  = 24,
  parameter int CW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CW-1:0]     in_chan,
  input logic [DW-1:0]     in_sample,
  input logic [NCH*DW-1:0] lo_lim,
  input logic [NCH*DW-1:0] hi_lim,
  input logic [2*NCH-1:0]  clamp_en,
  input logic              out_valid,
  input logic [DW-1:0]     out_sample,
  input logic [2*NCH-1:0]  sat_stat
);

  logic [DW-1:0] lo_c [NCH];
  logic [DW-1:0] hi_c [NCH];
  logic [NCH-1:0] lo_on_c, hi_on_c;

  for (genvar c = 0; c < NCH; c++) begin : g_k
    assign lo_c[c]    = lo_lim[c*DW +: DW];
    assign hi_c[c]    = hi_lim[c*DW +: DW];
    assign lo_on_c[c] = clamp_en[2*c];
    assign hi_on_c[c] = clamp_en[2*c+1];
  end

  wire [DW-1:0] lo_s = lo_c[in_chan];
  wire [DW-1:0] hi_s = hi_c[in_chan];
  wire lo_cond = lo_on_c[in_chan] && ($signed(in_sample) < $signed(lo_s));
  wire hi_cond = hi_on_c[in_chan] && ($signed(in_sample) > $signed(hi_s));

  // R2
  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sat_stat) && $stable(out_sample)));
  // R3, R9
  p_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lo_cond) |=> (out_sample == $past(lo_s)));
  // R4
  p_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hi_cond && !lo_cond) |=> (out_sample == $past(hi_s)));
  // R5, R6, R7
  p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lo_cond && !hi_cond) |=> (out_sample == $past(in_sample)));

endmodule

bind sat_clamp sat_clamp_chk #(.NCH(NCH), .DW(DW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
  .in_sample(in_sample), .lo_lim(lo_lim), .hi_lim(hi_lim), .clamp_en(clamp_en),
  .out_valid(out_valid), .out_sample(out_sample), .sat_stat(sat_stat)
);

// File: tb/sat_clamp_tb_top.sv
`timescale 1ns/1ps
module sat_clamp_tb_top;
  localparam int NCH = 16;
  localparam int DW  = 24;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [3:0] in_chan = 0;
  logic [DW-1:0] in_sample = 0;
  logic [NCH*DW-1:0] lo_lim = 0, hi_lim = 0;
  logic [2*NCH-1:0] clamp_en = 0;
  logic out_valid;
  logic [DW-1:0] out_sample;
  logic [2*NCH-1:0] sat_stat;

  always #10 clk = ~clk;

  sat_clamp dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_sample(in_sample), .lo_lim(lo_lim), .hi_lim(hi_lim), .clamp_en(clamp_en),
    .out_valid(out_valid), .out_sample(out_sample), .sat_stat(sat_stat));

  typedef struct { logic [DW-1:0] s; logic [2*NCH-1:0] st; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  logic [2*NCH-1:0] exp_st = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_lim(int c, int lo, int hi);
    lo_lim[c*DW +: DW] = DW'(lo);
    hi_lim[c*DW +: DW] = DW'(hi);
  endtask

  task automatic send(int c, int smp, string tag);
    logic [DW-1:0] s, lo, hi, r;
    bit blo, bhi;
    item_t it;
    s  = DW'(smp);
    lo = lo_lim[c*DW +: DW];
    hi = hi_lim[c*DW +: DW];
    blo = clamp_en[2*c]   && ($signed(s) < $signed(lo));
    bhi = clamp_en[2*c+1] && ($signed(s) > $signed(hi));
    r = blo ? lo : (bhi ? hi : s);
    exp_st[2*c]   = blo;
    exp_st[2*c+1] = bhi;
    it.s = r; it.st = exp_st; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    in_valid = 1; in_chan = 4'(c); in_sample = s;
    @(negedge clk);
    in_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) chk(0, "R2", "unexpected out_valid", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(out_sample == it.s, it.tag, "out_sample", out_sample, it.s);
        chk(sat_stat == it.st, it.tag, "sat_stat", sat_stat, it.st);
      end
    end
  end

  task automatic idle_check(int n);
    logic [2*NCH-1:0] st0;
    logic [DW-1:0] s0;
    st0 = sat_stat; s0 = out_sample;
    repeat (n) @(negedge clk);
    chk(out_valid == 0, "R2", "out_valid idle", out_valid, 0);
    chk(sat_stat == st0, "R8", "stat held idle", sat_stat, st0);
    chk(out_sample == s0, "R8", "sample held idle", out_sample, s0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WATCHDOG", "timeout", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) set_lim(c, -1000*(c+1), 1000*(c+1));
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(out_sample == 0, "R1", "out_sample", out_sample, 0);
    chk(sat_stat == 0, "R1", "sat_stat", sat_stat, 0);
    rst_n = 1;
    @(negedge clk);

    // R6: all clamps off, extreme samples pass
    send(0, -5000, "R6");
    send(0, 5000, "R6");
    send(9, 8388607, "R6");
    // R3 / R4 / R5 with all enabled
    clamp_en = '1;
    send(0, -5000, "R3");
    send(0, 5000, "R4");
    send(3, -4000, "R5");
    send(3, 4000, "R5");
    send(3, -3999, "R5");
    send(5, 123, "R4");
    send(0, -1001, "R3");
    idle_check(4);
    // R8: channel 0 status kept while other channels run
    send(0, -9000, "R8");
    send(6, 100, "R8");
    send(8, 20000, "R8");
    idle_check(3);
    // R6 mapping: channel 1 low only (bit 2), channel 2 high only (bit 5)
    clamp_en = 0;
    clamp_en[2] = 1;
    clamp_en[5] = 1;
    send(1, 9000, "R6");
    send(1, -9000, "R6");
    send(2, -9000, "R6");
    send(2, 9000, "R6");
    // R7: signed extremes
    send(2, -8388608, "R7");
    send(1, 8388607, "R7");
    clamp_en = '1;
    send(2, -8388608, "R7");
    send(1, 8388607, "R7");
    // R10: same sample on channels with different limits
    send(1, 2500, "R10");
    send(4, 2500, "R10");
    send(1, -2500, "R10");
    send(4, -2500, "R10");
    // R9: crossed limits on channel 7
    set_lim(7, 500, -500);
    @(negedge clk);
    send(7, 0, "R9");
    send(7, 600, "R9");
    send(7, -600, "R9");
    // back-to-back samples
    q.push_back('{s: DW'(-1000), st: 0, tag: "R2"});
    @(negedge clk);
    in_valid = 1; in_chan = 0; in_sample = DW'(-1000);
    begin
      item_t it;
      exp_st[1:0] = 2'b00;
      q[q.size()-1].st = exp_st;
      it.s = DW'(16000); exp_st[31:30] = 2'b00; it.st = exp_st; it.tag = "R2";
      q.push_back(it);
    end
    @(negedge clk);
    in_chan = 15; in_sample = DW'(16000);
    @(negedge clk);
    in_valid = 0;
    idle_check(3);
    chk(q.size() == 0, "R2", "outputs missing", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule